// File: doc/BRIEF.md
# Burst Header Offset Rewriter

This block sits on the electronic control path of a switch input module. It takes parsed burst header cells and gives each one the local time from a free-running counter as it is accepted. Each header then waits in a queue. When a header leaves, the block rewrites its offset field, which is the time gap between the header and its data burst. The new value takes away the time the header spent queued inside the block and adds a signed correction for the wavelength the header arrived on. With this rewrite the next stage sees a consistent gap even though the control delay varies.

On the way out, the block also replaces the channel field with the channel chosen for forwarding. It stamps the header with the departure time and passes the burst length through unchanged. A header whose corrected offset would fall below zero is still forwarded, but it is marked deleted and carries a zero offset. A software-written table holds the correction for each arrival channel.

Top module: `bhdr_offset_rewriter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and every entry of the correction table is 0, so a header leaves with only its queueing time removed.
- R2: Headers leave in the order they were accepted (first in, first out), and `out_len` equals the accepted `in_len`.
- R3: `out_chan` equals the `in_fwd_chan` value accepted with that header.
- R4: `out_stamp` equals `now_time` in the cycle the header is presented at the output.
- R5: `out_offset` equals `in_offset − E + C`, where E is `now_time` at the output minus `now_time` on the accepting edge, and C is the table entry of the header's `in_chan` (two's complement, `SKEW_W` bits).
- R6: E is computed modulo 2^`TS_W`, so it is correct when the time counter wraps while the header is queued.
- R7: When `in_offset − E + C` is negative, `out_del` is 1 and `out_offset` is 0. Otherwise `out_del` is 0, and a result of exactly 0 is forwarded as 0.
- R8: When `in_offset − E + C` exceeds 2^`OFS_W`−1, `out_offset` is all ones and `out_del` is 0.
- R9: Once `DEPTH` headers are queued, `in_ready` is 0, and a header offered while `in_ready` is 0 never enters the queue.
- R10: A write with `tbl_we` high sets entry `tbl_addr` to `tbl_wdata` on that clock edge. The table is read when a header departs, so a write made while a header is queued applies to that header.
- R11: While `out_valid` is 1 and `out_ready` is 0, the head header stays in place, and `out_chan` and `out_len` are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| now_time | input | TS_W | Free-running local time counter |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Queue can accept a header |
| in_chan | input | CH_W | Channel the header arrived on (indexes the correction table) |
| in_fwd_chan | input | CH_W | Channel the burst is forwarded on |
| in_offset | input | OFS_W | Header-to-burst time gap, unsigned |
| in_len | input | LEN_W | Burst length |
| tbl_we | input | 1 | Correction table write enable |
| tbl_addr | input | CH_W | Correction table entry to write |
| tbl_wdata | input | SKEW_W | Signed correction value |
| out_valid | output | 1 | Output header valid |
| out_ready | input | 1 | Downstream takes the header |
| out_chan | output | CH_W | Rewritten channel field |
| out_offset | output | OFS_W | Rewritten offset |
| out_len | output | LEN_W | Burst length, unchanged |
| out_stamp | output | TS_W | Departure timestamp |
| out_del | output | 1 | Header marked deleted (offset underflow) |

## Verification
A wrong receive stamp or correction entry appears at once as a wrong `out_offset` for the header at the head of the queue. Because the offset is computed from the live time counter, its error shows up in the first cycle that header is presented. A queue pointer or occupancy fault shows up one cycle after a push or pop, as a length or channel out of order, a lost or repeated header, or `in_ready` at the wrong fill level. Faults in the sign or clamp logic show only in the header whose corrected value crosses zero or the top of the offset range. The bench therefore places headers exactly on those edges, and also across a counter wrap.

// File: rtl/bhdr_pkg.sv
package bhdr_pkg;

  parameter int DEF_CH_W   = 4;
  parameter int DEF_OFS_W  = 16;
  parameter int DEF_TS_W   = 12;
  parameter int DEF_SKEW_W = 8;
  parameter int DEF_LEN_W  = 12;
  parameter int DEF_DEPTH  = 8;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bhdr_rst_sync.sv
module bhdr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/bhdr_fifo.sv
module bhdr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign push_ready = (cnt_q != FULL);
  assign pop_valid  = (cnt_q != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign pop_data   = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/bhdr_skew_table.sv
module bhdr_skew_table #(
  parameter int CH_W   = 4,
  parameter int SKEW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_addr,
  input  logic [SKEW_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [SKEW_W-1:0] rd_data
);
  localparam int NCH = 1 << CH_W;

  logic [SKEW_W-1:0] tbl_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q[g] <= '0;
      else if (ent_en) tbl_q[g] <= wr_data;
    end
  end

  assign rd_data = tbl_q[rd_addr];
endmodule

// File: rtl/bhdr_offset_calc.sv
module bhdr_offset_calc #(
  parameter int OFS_W  = 16,
  parameter int TS_W   = 12,
  parameter int SKEW_W = 8
) (
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic [TS_W-1:0]   stamp,
  input  logic [TS_W-1:0]   now,
  input  logic [SKEW_W-1:0] skew,
  output logic [OFS_W-1:0]  ofs_out,
  output logic              del
);
  localparam int SW = bhdr_pkg::max_of(bhdr_pkg::max_of(OFS_W, TS_W), SKEW_W) + 2;

  logic [TS_W-1:0] elapsed;
  logic [SW-1:0]   ofs_x, el_x, sk_x, sum;
  logic            neg, over;

  always_comb begin
    elapsed = now - stamp;
    ofs_x   = {{(SW - OFS_W){1'b0}}, ofs_in};
    el_x    = {{(SW - TS_W){1'b0}}, elapsed};
    sk_x    = {{(SW - SKEW_W){skew[SKEW_W-1]}}, skew};
    sum     = ofs_x - el_x + sk_x;
    neg     = sum[SW-1];
    over    = !neg && (|sum[SW-2:OFS_W]);
    del     = neg;
    if (neg)       ofs_out = '0;
    else if (over) ofs_out = '1;
    else           ofs_out = sum[OFS_W-1:0];
  end
endmodule

// File: rtl/bhdr_offset_rewriter.sv
module bhdr_offset_rewriter
  import bhdr_pkg::*;
#(
  parameter int CH_W   = DEF_CH_W,
  parameter int OFS_W  = DEF_OFS_W,
  parameter int TS_W   = DEF_TS_W,
  parameter int SKEW_W = DEF_SKEW_W,
  parameter int LEN_W  = DEF_LEN_W,
  parameter int DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now_time,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [CH_W-1:0]   in_fwd_chan,
  input  logic [OFS_W-1:0]  in_offset,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              tbl_we,
  input  logic [CH_W-1:0]   tbl_addr,
  input  logic [SKEW_W-1:0] tbl_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [OFS_W-1:0]  out_offset,
  output logic [LEN_W-1:0]  out_len,
  output logic [TS_W-1:0]   out_stamp,
  output logic              out_del
);
  localparam int ENT_W  = 2 * CH_W + OFS_W + LEN_W + TS_W;
  localparam int P_TS   = 0;
  localparam int P_LEN  = P_TS + TS_W;
  localparam int P_OFS  = P_LEN + LEN_W;
  localparam int P_CH   = P_OFS + OFS_W;
  localparam int P_FWD  = P_CH + CH_W;

  logic              rst_sync_n;
  logic [ENT_W-1:0]  push_ent, head_ent;
  logic [CH_W-1:0]   head_ch, head_fwd;
  logic [OFS_W-1:0]  head_ofs;
  logic [LEN_W-1:0]  head_len;
  logic [TS_W-1:0]   head_ts;
  logic [SKEW_W-1:0] head_skew;

  bhdr_rst_sync rst_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign push_ent = {in_fwd_chan, in_chan, in_offset, in_len, now_time};

  bhdr_fifo #(.W(ENT_W), .DEPTH(DEPTH)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_valid (in_valid),
    .push_ready (in_ready),
    .push_data  (push_ent),
    .pop_valid  (out_valid),
    .pop_ready  (out_ready),
    .pop_data   (head_ent)
  );

  assign head_ts  = head_ent[P_TS  +: TS_W];
  assign head_len = head_ent[P_LEN +: LEN_W];
  assign head_ofs = head_ent[P_OFS +: OFS_W];
  assign head_ch  = head_ent[P_CH  +: CH_W];
  assign head_fwd = head_ent[P_FWD +: CH_W];

  bhdr_skew_table #(.CH_W(CH_W), .SKEW_W(SKEW_W)) tbl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (head_ch),
    .rd_data (head_skew)
  );

  bhdr_offset_calc #(.OFS_W(OFS_W), .TS_W(TS_W), .SKEW_W(SKEW_W)) calc_i (
    .ofs_in  (head_ofs),
    .stamp   (head_ts),
    .now     (now_time),
    .skew    (head_skew),
    .ofs_out (out_offset),
    .del     (out_del)
  );

  assign out_chan  = head_fwd;
  assign out_len   = head_len;
  assign out_stamp = now_time;
endmodule

// File: rtl/bhdr_offset_rewriter_chk.sv
module bhdr_offset_rewriter_chk #(
  parameter int CH_W  = 4,
  parameter int OFS_W = 16,
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CH_W-1:0]  out_chan,
  input logic [LEN_W-1:0] out_len,
  input logic [OFS_W-1:0] out_offset,
  input logic             out_del
);
  // R9
  full_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R1
  empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_len)));

  // R7
  del_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_del) |-> (out_offset == '0));
endmodule

bind bhdr_offset_rewriter bhdr_offset_rewriter_chk #(
  .CH_W(CH_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_chan   (out_chan),
  .out_len    (out_len),
  .out_offset (out_offset),
  .out_del    (out_del)
);

// File: tb/bhdr_offset_rewriter_tb.sv
module bhdr_offset_rewriter_tb_top;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [3:0]  ch;
    logic [3:0]  fwd;
    logic [15:0] ofs;
    logic [11:0] len;
    logic [7:0]  wt;
    logic        del;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t [0:NV-1] VECS = '{
    '{ch: 4'd0,  fwd: 4'd7,  ofs: 16'd1000,  len: 12'd64,   wt: 8'd1,  del: 1'b0},
    '{ch: 4'd1,  fwd: 4'd2,  ofs: 16'd500,   len: 12'd1,    wt: 8'd20, del: 1'b0},
    '{ch: 4'd2,  fwd: 4'd9,  ofs: 16'd40,    len: 12'd4095, wt: 8'd37, del: 1'b0},
    '{ch: 4'd2,  fwd: 4'd3,  ofs: 16'd40,    len: 12'd5,    wt: 8'd38, del: 1'b1},
    '{ch: 4'd15, fwd: 4'd15, ofs: 16'd200,   len: 12'd77,   wt: 8'd3,  del: 1'b0},
    '{ch: 4'd3,  fwd: 4'd0,  ofs: 16'd65500, len: 12'd300,  wt: 8'd2,  del: 1'b0},
    '{ch: 4'd0,  fwd: 4'd11, ofs: 16'd0,     len: 12'd9,    wt: 8'd1,  del: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] tnow = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0, tbl_we = 1'b0;
  logic        in_ready, out_valid, out_del;
  logic [3:0]  in_chan = '0, in_fwd_chan = '0, tbl_addr = '0, out_chan;
  logic [15:0] in_offset = '0, out_offset;
  logic [11:0] in_len = '0, out_len, out_stamp;
  logic [7:0]  tbl_wdata = '0;

  int errors = 0;
  int checks = 0;
  int skm [16];
  logic [11:0] ts_log [DEPTH];

  always #5 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 12'd1;

  bhdr_offset_rewriter dut_i (
    .clk(clk), .rst_n(rst_n), .now_time(tnow),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_fwd_chan(in_fwd_chan), .in_offset(in_offset), .in_len(in_len),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_offset(out_offset), .out_len(out_len), .out_stamp(out_stamp),
    .out_del(out_del)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int ofs, input logic [11:0] ts, input logic [3:0] ch,
                               output bit del);
    logic [11:0] el;
    int e;
    el = tnow - ts;
    e = ofs - int'(el) + skm[ch];
    del = (e < 0);
    if (e < 0) return 0;
    if (e > 65535) return 65535;
    return e;
  endfunction

  task automatic tbl_write(input logic [3:0] a, input int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = 8'(v);
    @(negedge clk);
    tbl_we = 1'b0;
    skm[a] = v;
  endtask

  task automatic push1(input logic [3:0] ch, input logic [3:0] fwd, input logic [15:0] ofs,
                       input logic [11:0] len, output logic [11:0] ts);
    in_valid = 1'b1; in_chan = ch; in_fwd_chan = fwd; in_offset = ofs; in_len = len;
    ts = tnow;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop1;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] ts;
    bit mdel;
    int mofs;
    foreach (skm[i]) skm[i] = 0;

    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);

    // R1: table is zero after reset
    push1(4'd5, 4'd6, 16'd100, 12'd33, ts);
    repeat (3) @(negedge clk);
    chk("R1", "offset with cleared table", out_offset, 96);
    chk("R1", "del with cleared table", out_del, 0);
    pop1();

    tbl_write(4'd1, 5);
    tbl_write(4'd2, -3);
    tbl_write(4'd3, 100);
    tbl_write(4'd15, -128);

    // vector table: R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      push1(VECS[v].ch, VECS[v].fwd, VECS[v].ofs, VECS[v].len, ts);
      repeat (int'(VECS[v].wt) - 1) @(negedge clk);
      mofs = model(int'(VECS[v].ofs), ts, VECS[v].ch, mdel);
      chk("R2", "out_valid", out_valid, 1);
      chk("R2", "len passthrough", out_len, VECS[v].len);
      chk("R3", "channel rewrite", out_chan, VECS[v].fwd);
      chk("R4", "departure stamp", out_stamp, tnow);
      chk("R5", "offset", out_offset, mofs);
      chk("R7", "deleted flag (table)", out_del, VECS[v].del);
      chk("R7", "deleted flag (model)", out_del, mdel);
      pop1();
      chk("R2", "queue empty after pop", out_valid, 0);
    end
    // spot values: R7 zero boundary and R8 clamp reached by vectors 2 and 5

    // R6: counter wrap while queued
    while (tnow != 12'd4090) @(negedge clk);
    push1(4'd0, 4'd4, 16'd300, 12'd12, ts);
    repeat (9) @(negedge clk);
    chk("R6", "wrap elapsed offset", out_offset, 290);
    chk("R6", "wrap stamp", out_stamp, 4);
    pop1();

    // R10: table written while header queued
    push1(4'd6, 4'd1, 16'd500, 12'd7, ts);
    tbl_write(4'd6, 20);
    @(negedge clk);
    mofs = model(500, ts, 4'd6, mdel);
    chk("R10", "late table write applied", out_offset, mofs);
    chk("R10", "late write offset value", out_offset, 500 - int'(12'(tnow - ts)) + 20);
    pop1();

    // R9: fill the queue, offer one more, R11 hold, R2 order
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1; in_chan = 4'd0; in_fwd_chan = 4'(i);
      in_offset = 16'd1000; in_len = 12'(100 + i);
      ts_log[i] = tnow;
      @(negedge clk);
    end
    in_len = 12'd999;
    chk("R9", "in_ready when full", in_ready, 0);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "head held", out_len, 100);
    chk("R9", "still full", in_ready, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2", "order len", out_len, 100 + i);
      chk("R3", "order chan", out_chan, i);
      chk("R5", "queued offset", out_offset, 1000 - int'(12'(tnow - ts_log[i])));
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R9", "blocked header never entered", out_valid, 0);
    chk("R9", "ready after drain", in_ready, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule